// File: doc/BRIEF.md
# Board System Control Register Block

A bus-slave register block for board-level control and status. It drives a set of active-high user LEDs, returns the state of push buttons and (optionally) slide switches, keeps two free-running time counters that advance once per second and once per hundredth of a second, holds a general-purpose 32-bit control word, and exposes the register window of a prescaled event counter, which lives in its own submodule.

Access is through a simple 32-bit bus with one-cycle transfers: a select, a write flag, a 12-bit byte offset covering a 4 KB window, and write and read data. Writes take effect at the clock edge of the cycle in which they are presented. Read data is combinational from the offset during a read cycle and is zero otherwise. Only whole 32-bit words at word-aligned offsets are decoded; any other offset is unmapped. The time counters derive their rates from the block clock through integer dividers set by the `CLK_HZ` parameter (which must be a multiple of 100). The prescaler counts block clock cycles.

Top module: `board_ctrl_regs`

## Requirements
- R1: While reset is asserted and after its release before any clock edge, the LED (0x00), one-second (0x10), hundredth (0x14), event count (0x18), reload (0x1C), prescale count (0x20) and control word (0x4C) registers read zero and `led_o` is zero.
- R2: A write to 0x00 stores only bits [NUM_LEDS-1:0]; the register reads back that masked value, `led_o[i]` equals stored bit i, and all `led_o` bits at or above NUM_LEDS are zero. With NUM_LEDS = 0 a write to 0x00 leaves the register and `led_o` at zero.
- R3: A read of 0x08 returns `btn_i` zero-extended to 32 bits; a write to 0x08 changes nothing.
- R4: With HAS_SW = 1 a read of 0x28 returns `sw_i` zero-extended; with HAS_SW = 0 offset 0x28 is unmapped and reads zero.
- R5: A read of any unmapped or non-word-aligned offset returns zero, a write there changes no register, and `rdata_o` is zero in any cycle that is not a read.
- R6: Offset 0x4C is a 32-bit register that reads back the last value written.
- R7: The register at 0x10 increments by one every CLK_HZ clock cycles; a write loads the written value and restarts the divider, so the first increment after the write occurs CLK_HZ edges after the writing edge.
- R8: The register at 0x14 behaves as R7 but with a period of CLK_HZ/100 clock cycles.
- R9: A write to 0x10 or 0x14 in the same cycle as that counter's increment loads the written value, with no increment applied.
- R10: Both time counters are 32 bits and wrap from 0xFFFFFFFF to 0.
- R11: On each clock edge the prescale count (0x20) decreases by one when nonzero; when it is zero it reloads from the reload register (0x1C) and the event count (0x18) increments.
- R12: With the reload register at zero, the prescale count stays at zero and the event count increments on every clock edge.
- R13: A write to 0x18, 0x1C or 0x20 loads that register with the written value, overriding the update R11 would apply to it in that cycle; the reload value used on that edge is the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the prescaler and time base source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Bus transfer in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the 4 KB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero outside read cycles |
| btn_i | input | BTN_W | Push button levels |
| sw_i | input | SW_W | Slide switch levels |
| led_o | output | LED_W | User LED drive, active high |

## Verification
The hardest case to reach from the ports is a bus write that lands on exactly the edge where a time counter would increment, since the divider phase is invisible at the bus. The stimulus first writes the counter to set a known divider phase, waits the precise number of cycles until the next increment edge, and writes again there; it then reads the value on the following cycle and again one full period later to show that the increment was dropped and the phase restarted. The same edge-alignment approach shows the prescaler reload and the wrap of a time counter preloaded to all ones.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] OFS_LED   = 12'h000;
  localparam logic [AW-1:0] OFS_BTN   = 12'h008;
  localparam logic [AW-1:0] OFS_SEC   = 12'h010;
  localparam logic [AW-1:0] OFS_CSEC  = 12'h014;
  localparam logic [AW-1:0] OFS_EVT   = 12'h018;
  localparam logic [AW-1:0] OFS_RLD   = 12'h01C;
  localparam logic [AW-1:0] OFS_PSC   = 12'h020;
  localparam logic [AW-1:0] OFS_SW    = 12'h028;
  localparam logic [AW-1:0] OFS_CTRL  = 12'h04C;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_LED,
    REG_BTN,
    REG_SEC,
    REG_CSEC,
    REG_EVT,
    REG_RLD,
    REG_PSC,
    REG_SW,
    REG_CTRL
  } reg_id_e;

  function automatic reg_id_e decode_ofs(logic [AW-1:0] ofs, bit has_sw);
    reg_id_e id;
    case (ofs)
      OFS_LED:  id = REG_LED;
      OFS_BTN:  id = REG_BTN;
      OFS_SEC:  id = REG_SEC;
      OFS_CSEC: id = REG_CSEC;
      OFS_EVT:  id = REG_EVT;
      OFS_RLD:  id = REG_RLD;
      OFS_PSC:  id = REG_PSC;
      OFS_SW:   id = has_sw ? REG_SW : REG_NONE;
      OFS_CTRL: id = REG_CTRL;
      default:  id = REG_NONE;
    endcase
    return id;
  endfunction

  function automatic logic [DW-1:0] low_mask(int n);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i < n);
    return m;
  endfunction

endpackage

// File: rtl/bc_time_base.sv
module bc_time_base #(
  parameter int DIV   = 100,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0]    phase_q;
  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step = (phase_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      count_q <= '0;
    end else if (load_i) begin
      phase_q <= '0;
      count_q <= load_val_i;
    end else begin
      phase_q <= step ? '0 : phase_q + 1'b1;
      if (step) count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i) && phase_q == '0));

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && phase_q != LAST) |=> $stable(count_o));

  // R10
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && phase_q == LAST && count_o == '1) |=> count_o == '0);

endmodule

// File: rtl/bc_presc_counter.sv
module bc_presc_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_evt_i,
  input  logic         wr_rld_i,
  input  logic         wr_psc_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] rld_o,
  output logic [W-1:0] psc_o
);

  logic [W-1:0] evt_q, rld_q, psc_q;
  logic         at_zero;

  assign at_zero = (psc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      rld_q <= '0;
      psc_q <= '0;
    end else begin
      if (wr_rld_i) rld_q <= wdata_i;

      if (wr_psc_i)     psc_q <= wdata_i;
      else if (at_zero) psc_q <= rld_q;
      else              psc_q <= psc_q - 1'b1;

      if (wr_evt_i)     evt_q <= wdata_i;
      else if (at_zero) evt_q <= evt_q + 1'b1;
    end
  end

  assign evt_o = evt_q;
  assign rld_o = rld_q;
  assign psc_o = psc_q;

  // R11
  psc_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_psc_i && psc_o != '0) |=> psc_o == $past(psc_o) - 1'b1);

  // R11
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_evt_i && psc_o != '0) |=> $stable(evt_o));

  // R12
  zero_rld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_evt_i && !wr_psc_i && psc_o == '0 && rld_o == '0)
      |=> (psc_o == '0 && evt_o == $past(evt_o) + 1'b1));

  // R13
  psc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_psc_i |=> psc_o == $past(wdata_i));

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int LED_W    = 8,
  parameter int BTN_W    = 4,
  parameter int SW_W     = 8,
  parameter bit HAS_SW   = 1'b0,
  parameter int CLK_HZ   = 25_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [BTN_W-1:0] btn_i,
  input  logic [SW_W-1:0]  sw_i,
  output logic [LED_W-1:0] led_o
);

  localparam int NTB = 2;
  localparam logic [LED_W-1:0] LED_MASK = LED_W'(low_mask(NUM_LEDS));

  reg_id_e     rid;
  logic        wr_en, rd_en;
  logic [DW-1:0] ctrl_q;
  logic [LED_W-1:0] led_q;
  logic [DW-1:0] evt, rld, psc;
  logic [NTB-1:0] tb_load;
  logic [DW-1:0] tb_cnt [NTB];
  logic [DW-1:0] rd_mux;

  assign rid   = decode_ofs(addr_i, HAS_SW);
  assign wr_en = sel_i & wr_i;
  assign rd_en = sel_i & ~wr_i;

  generate
    if (NUM_LEDS == 0) begin : g_no_led
      assign led_q = '0;
    end else begin : g_led
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     led_q <= '0;
        else if (wr_en && rid == REG_LED) led_q <= wdata_i[LED_W-1:0] & LED_MASK;
      end
    end
  endgenerate

  assign led_o = led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ctrl_q <= '0;
    else if (wr_en && rid == REG_CTRL) ctrl_q <= wdata_i;
  end

  assign tb_load[0] = wr_en && rid == REG_SEC;
  assign tb_load[1] = wr_en && rid == REG_CSEC;

  for (genvar g = 0; g < NTB; g++) begin : g_tb
    bc_time_base #(
      .DIV   ((g == 0) ? CLK_HZ : CLK_HZ / 100),
      .CNT_W (DW)
    ) i_tb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tb_load[g]),
      .load_val_i (wdata_i),
      .count_o    (tb_cnt[g])
    );
  end

  bc_presc_counter #(.W(DW)) i_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_evt_i (wr_en && rid == REG_EVT),
    .wr_rld_i (wr_en && rid == REG_RLD),
    .wr_psc_i (wr_en && rid == REG_PSC),
    .wdata_i  (wdata_i),
    .evt_o    (evt),
    .rld_o    (rld),
    .psc_o    (psc)
  );

  always_comb begin
    case (rid)
      REG_LED:  rd_mux = DW'(led_q);
      REG_BTN:  rd_mux = DW'(btn_i);
      REG_SEC:  rd_mux = tb_cnt[0];
      REG_CSEC: rd_mux = tb_cnt[1];
      REG_EVT:  rd_mux = evt;
      REG_RLD:  rd_mux = rld;
      REG_PSC:  rd_mux = psc;
      REG_SW:   rd_mux = DW'(sw_i);
      REG_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = '0;
    endcase
  end

  assign rdata_o = rd_en ? rd_mux : '0;

  // R2
  led_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_o & ~LED_MASK) == '0);

  // R5
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |-> rdata_o == '0);

  // R6
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && addr_i == OFS_CTRL) |=> $stable(ctrl_q));

  // R3
  btn_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && addr_i == OFS_BTN) |-> rdata_o == DW'(btn_i));

endmodule

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 400;
  localparam int CSEC_DIV   = HZ / 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [3:0]  btn = '0;
  logic [7:0]  sw = '0;
  logic [7:0]  led_a, led_b;
  logic [31:0] ra, rb;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  board_ctrl_regs #(.NUM_LEDS(2), .HAS_SW(1'b1), .CLK_HZ(HZ)) i_board_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .btn_i(btn), .sw_i(sw), .led_o(led_a));

  board_ctrl_regs #(.NUM_LEDS(0), .HAS_SW(1'b0), .CLK_HZ(HZ)) i_board_ctrl_regs_b (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .btn_i(btn), .sw_i(sw), .led_o(led_b));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at the following negedge
  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  // called at a negedge; samples state after the previous posedge; returns one negedge later
  task automatic bus_rd(logic [11:0] a);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    ra = rdata_a; rb = rdata_b;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [11:0] ofs [7] = '{12'h000, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h04C};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    foreach (ofs[i]) begin
      sel = 1'b1; wr = 1'b0; addr = ofs[i]; #1;
      chk("R1 reset read", rdata_a, 32'h0);
    end
    sel = 1'b0;
    chk("R1 reset led_o", 32'(led_a), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_led;
    bus_wr(12'h000, 32'hFFFF_FFFD);
    bus_rd(12'h000);
    chk("R2 led mask readback", ra, 32'h1);
    chk("R2 led_o", 32'(led_a), 32'h01);
    chk("R2 zero leds readback", rb, 32'h0);
    chk("R2 zero leds led_o", 32'(led_b), 32'h0);
    bus_wr(12'h000, 32'h0000_0006);
    bus_rd(12'h000);
    chk("R2 led readback 2", ra, 32'h2);
    chk("R2 led_o 2", 32'(led_a), 32'h02);
  endtask

  task automatic t_btn;
    btn = 4'b1010;
    bus_rd(12'h008);
    chk("R3 button read", ra, 32'hA);
    bus_wr(12'h008, 32'h5);
    bus_rd(12'h008);
    chk("R3 button after write", ra, 32'hA);
    btn = 4'b0001;
    bus_rd(12'h008);
    chk("R3 button follows input", ra, 32'h1);
  endtask

  task automatic t_sw;
    sw = 8'hA5;
    bus_rd(12'h028);
    chk("R4 switch enabled", ra, 32'hA5);
    chk("R4 switch disabled", rb, 32'h0);
  endtask

  task automatic t_ctrl_unmapped;
    bus_wr(12'h04C, 32'hDEAD_BEEF);
    bus_rd(12'h04C);
    chk("R6 control readback", ra, 32'hDEAD_BEEF);
    bus_wr(12'h004, 32'h1234_5678);
    bus_wr(12'h04E, 32'h0);
    bus_wr(12'hFFC, 32'h0);
    bus_rd(12'h04C);
    chk("R5 control untouched", ra, 32'hDEAD_BEEF);
    bus_rd(12'h000);
    chk("R5 led untouched", ra, 32'h2);
    bus_rd(12'h004);
    chk("R5 unmapped read", ra, 32'h0);
    bus_rd(12'h04D);
    chk("R5 misaligned read", ra, 32'h0);
    bus_rd(12'hFFC);
    chk("R5 top read", ra, 32'h0);
    #1;
    chk("R5 idle rdata", rdata_a, 32'h0);
  endtask

  task automatic t_csec;
    bus_wr(12'h014, 32'h0000_0050);      // lands P0
    bus_rd(12'h014);                     // after P0
    chk("R8 load value", ra, 32'h50);
    repeat (CSEC_DIV - 2) @(negedge clk);
    bus_rd(12'h014);                     // after P(DIV-1)
    chk("R8 hold before period", ra, 32'h50);
    bus_rd(12'h014);                     // after P(DIV)
    chk("R8 increment", ra, 32'h51);
    // write on the increment edge
    bus_wr(12'h014, 32'h0000_0100);      // lands P0
    repeat (CSEC_DIV - 1) @(negedge clk);
    bus_wr(12'h014, 32'h0000_0200);      // lands P(DIV), an increment edge
    bus_rd(12'h014);
    chk("R9 write beats tick", ra, 32'h200);
    repeat (CSEC_DIV - 2) @(negedge clk);
    bus_rd(12'h014);
    chk("R9 phase restarted hold", ra, 32'h200);
    bus_rd(12'h014);
    chk("R9 phase restarted step", ra, 32'h201);
    // wrap
    bus_wr(12'h014, 32'hFFFF_FFFF);
    repeat (CSEC_DIV - 1) @(negedge clk);
    bus_rd(12'h014);
    chk("R10 before wrap", ra, 32'hFFFF_FFFF);
    bus_rd(12'h014);
    chk("R10 wrap to zero", ra, 32'h0);
  endtask

  task automatic t_sec;
    bus_wr(12'h010, 32'd10);
    repeat (HZ - 1) @(negedge clk);
    bus_rd(12'h010);
    chk("R7 hold full period", ra, 32'd10);
    bus_rd(12'h010);
    chk("R7 increment", ra, 32'd11);
  endtask

  task automatic t_presc;
    bus_wr(12'h018, 32'h0);              // reload is 0, pscntr 0
    bus_rd(12'h018);
    chk("R13 event write wins", ra, 32'h0);
    bus_rd(12'h018);
    chk("R12 event per clock", ra, 32'h1);
    bus_rd(12'h020);
    chk("R12 prescale stays zero", ra, 32'h0);
    bus_wr(12'h01C, 32'h2);              // P0: reload used is old zero
    bus_wr(12'h020, 32'h3);              // P1
    bus_wr(12'h018, 32'd100);            // P2: psc 3->2
    bus_rd(12'h020);
    chk("R11 count down", ra, 32'h2);
    bus_rd(12'h018);
    chk("R13 event loaded", ra, 32'd100);
    bus_rd(12'h020);
    chk("R11 reaches zero", ra, 32'h0);
    bus_rd(12'h018);
    chk("R11 event step on reload", ra, 32'd101);
    bus_rd(12'h020);
    chk("R11 reloaded count", ra, 32'h1);
    @(negedge clk);
    bus_rd(12'h018);
    chk("R11 second reload", ra, 32'd102);
    bus_rd(12'h01C);
    chk("R13 reload readback", ra, 32'h2);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 200_000);
        n_tests++; n_fail++;
        $display("FAIL watchdog got=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none
    @(negedge clk);
    t_reset();
    t_led();
    t_btn();
    t_sw();
    t_ctrl_unmapped();
    t_csec();
    t_sec();
    t_presc();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule